// File: doc/BRIEF.md
# Streaming Error Field Adapter

This block sits between a streaming producer and a streaming consumer that agree on every field except the error field. Payload, valid, start-of-packet, end-of-packet and channel fields go across as plain wires, and the ready signal goes back from consumer to producer untouched. Each side may carry an error field of its own width. Either side may have no error field at all. The adapter re-maps the error bits from one side to the other using a type tag attached to every bit.

Routing is fixed when the block is elaborated. A consumer bit is fed by the first still-free producer bit that has the same tag. The lowest-numbered consumer bit tagged as the catch-all receives the OR of every producer bit left over after tag matching. All other consumer bits are held at 0. Producer bits that end up with no consumer are dropped. The block has no clock, no state and no effect on handshake timing.

Top module: `st_err_adapter`

## Requirements
- R1: `snk_data`, `snk_sop`, `snk_eop`, `snk_chan` and `snk_valid` equal `src_data`, `src_sop`, `src_eop`, `src_chan` and `src_valid` at all times.
- R2: `src_ready` equals `snk_ready` at all times.
- R3: Tags are TAG_W-bit codes. The tag of error bit i sits at bits [i*TAG_W +: TAG_W] of `SRC_TAGS` or `SNK_TAGS`, and code 0 is the catch-all tag. A consumer bit with a nonzero tag follows the producer bit with the same tag that it was matched to.
- R4: Consumer bits are matched in ascending index order. Each one takes the lowest-index producer bit with the same tag that no lower consumer bit has taken, so each producer bit feeds at most one consumer bit by tag.
- R5: The lowest-index consumer bit with tag 0 equals the OR of all producer bits not taken by tag matching, whatever their tags, including tag 0.
- R6: Every consumer bit with tag 0 other than the lowest-index one is 0.
- R7: A consumer bit with a nonzero tag that finds no free producer bit with the same tag is 0.
- R8: When there is no catch-all consumer bit, producer bits left unmatched have no effect on `snk_err`. When all producer error bits are 0, `snk_err` is 0.
- R9: A side with error width 0 still has a 1-bit port. If SRC_W is 0, `src_err` is ignored. If SNK_W is 0, `snk_err` is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_valid | input | 1 | Producer valid |
| src_ready | output | 1 | Ready returned to the producer |
| src_data | input | DATA_W | Producer payload |
| src_sop | input | 1 | Producer start of packet |
| src_eop | input | 1 | Producer end of packet |
| src_chan | input | CH_W | Producer channel number |
| src_err | input | max(SRC_W,1) | Producer error bits |
| snk_valid | output | 1 | Consumer valid |
| snk_ready | input | 1 | Consumer ready |
| snk_data | output | DATA_W | Consumer payload |
| snk_sop | output | 1 | Consumer start of packet |
| snk_eop | output | 1 | Consumer end of packet |
| snk_chan | output | CH_W | Consumer channel number |
| snk_err | output | max(SNK_W,1) | Consumer error bits |

## Verification
The assertions assume the producer error bits are known (not X) whenever they are evaluated. They also assume the tag parameters describe no more bits than MAX_ERR. They ignore the unused bit of a zero-width side. The bench keeps to these assumptions: it drives every input from declared values at time zero, uses only fully known random or directed error patterns, and builds five fixed tag maps that stay within MAX_ERR. Those maps cover direct matching, repeated tags, several catch-all bits, no catch-all, and a missing field on each side.

// File: rtl/st_err_adapter_pkg.sv
package st_err_adapter_pkg;
   // tag code that marks a catch-all error bit
   localparam int TAG_CATCH_ALL = 0;
   // returned by the matcher when no producer bit is found
   localparam int NO_SOURCE = -1;

   function automatic int port_width(input int w);
      return (w < 1) ? 1 : w;
   endfunction
endpackage

// File: rtl/st_passthru.sv
module st_passthru #(
   parameter int DATA_W = 32,
   parameter int CH_W   = 4
) (
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [CH_W-1:0]   in_chan,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic [CH_W-1:0]   out_chan,
   output logic              in_ready
);
   assign out_valid = in_valid;
   assign out_data  = in_data;
   assign out_sop   = in_sop;
   assign out_eop   = in_eop;
   assign out_chan  = in_chan;
   assign in_ready  = out_ready;
endmodule

// File: rtl/err_leftover_or.sv
module err_leftover_or #(
   parameter int          N    = 4,
   parameter logic [N-1:0] MASK = '0
) (
   input  logic [N-1:0] vec,
   output logic         any
);
   always_comb begin
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (MASK[i]) any = any | vec[i];
      end
   end
endmodule

// File: rtl/err_router.sv
module err_router
   import st_err_adapter_pkg::*;
#(
   parameter int                     MAX_ERR  = 8,
   parameter int                     TAG_W    = 8,
   parameter int                     SRC_W    = 2,
   parameter int                     SNK_W    = 2,
   parameter logic [MAX_ERR*TAG_W-1:0] SRC_TAGS = '0,
   parameter logic [MAX_ERR*TAG_W-1:0] SNK_TAGS = '0,
   localparam int                    SRC_PW   = port_width(SRC_W),
   localparam int                    SNK_PW   = port_width(SNK_W)
) (
   input  logic [SRC_PW-1:0] src_err,
   output logic [SNK_PW-1:0] snk_err
);
   function automatic int src_tag(input int i);
      return int'(SRC_TAGS[i*TAG_W +: TAG_W]);
   endfunction

   function automatic int snk_tag(input int k);
      return int'(SNK_TAGS[k*TAG_W +: TAG_W]);
   endfunction

   // producer bit chosen for consumer bit k, walking consumer bits in order
   function automatic int match_src(input int k);
      logic [MAX_ERR-1:0] used;
      int hit;
      int result;
      used   = '0;
      result = NO_SOURCE;
      for (int j = 0; j < SNK_W; j++) begin
         hit = NO_SOURCE;
         if (snk_tag(j) != TAG_CATCH_ALL) begin
            for (int i = 0; i < SRC_W; i++) begin
               if (hit == NO_SOURCE && !used[i] && src_tag(i) == snk_tag(j)) hit = i;
            end
         end
         if (hit != NO_SOURCE) used[hit] = 1'b1;
         if (j == k) result = hit;
      end
      return result;
   endfunction

   // producer bits left over after all tag matches
   function automatic logic [SRC_PW-1:0] leftover_mask();
      logic [SRC_PW-1:0] m;
      int s;
      m = '0;
      for (int i = 0; i < SRC_W; i++) m[i] = 1'b1;
      for (int k = 0; k < SNK_W; k++) begin
         s = match_src(k);
         if (s != NO_SOURCE) m[s] = 1'b0;
      end
      return m;
   endfunction

   function automatic int catch_index();
      int c;
      c = NO_SOURCE;
      for (int k = SNK_W - 1; k >= 0; k--) begin
         if (snk_tag(k) == TAG_CATCH_ALL) c = k;
      end
      return c;
   endfunction

   localparam logic [SRC_PW-1:0] LEFT_MASK = leftover_mask();
   localparam int                CATCH_K   = catch_index();

   logic [SRC_PW-1:0] src_eff;
   logic              left_any;

   generate
      if (SRC_W == 0) begin : g_no_src
         assign src_eff = '0;
      end else begin : g_src
         assign src_eff = src_err;
      end
   endgenerate

   err_leftover_or #(
      .N    (SRC_PW),
      .MASK (LEFT_MASK)
   ) u_left (
      .vec (src_eff),
      .any (left_any)
   );

   generate
      if (SNK_W == 0) begin : g_no_snk
         assign snk_err = 1'b0;
      end else begin : g_snk
         for (genvar k = 0; k < SNK_W; k++) begin : g_bit
            localparam int SRC_IDX = match_src(k);
            if (SRC_IDX != NO_SOURCE) begin : g_tagged
               assign snk_err[k] = src_eff[SRC_IDX];
            end else if (k == CATCH_K) begin : g_catch
               assign snk_err[k] = left_any;
            end else begin : g_tie
               assign snk_err[k] = 1'b0;
            end
         end
      end
   endgenerate

   // checks beside the routing
   always_comb begin
      if (!$isunknown(src_eff)) begin
         p_count_r4: assert ($countones(snk_err) <= $countones(src_eff))
            else $error("consumer error bits outnumber producer error bits");
         p_quiet_r8: assert ((|src_eff) || !(|snk_err))
            else $error("consumer error set with no producer error");
         if (SRC_W == 0 || SNK_W == 0) begin
            p_zero_side_r9: assert (snk_err == '0)
               else $error("zero-width side yet consumer error set");
         end
         if (CATCH_K != NO_SOURCE) begin
            p_catch_r5: assert (snk_err[CATCH_K] == |(src_eff & LEFT_MASK))
               else $error("catch-all bit differs from leftover OR");
         end
      end
   end
endmodule

// File: rtl/st_err_adapter.sv
module st_err_adapter
   import st_err_adapter_pkg::*;
#(
   parameter int                     DATA_W   = 32,
   parameter int                     CH_W     = 4,
   parameter int                     MAX_ERR  = 8,
   parameter int                     TAG_W    = 8,
   parameter int                     SRC_W    = 2,
   parameter int                     SNK_W    = 2,
   parameter logic [MAX_ERR*TAG_W-1:0] SRC_TAGS = '0,
   parameter logic [MAX_ERR*TAG_W-1:0] SNK_TAGS = '0,
   localparam int                    SRC_PW   = port_width(SRC_W),
   localparam int                    SNK_PW   = port_width(SNK_W)
) (
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_sop,
   input  logic              src_eop,
   input  logic [CH_W-1:0]   src_chan,
   input  logic [SRC_PW-1:0] src_err,
   output logic              snk_valid,
   input  logic              snk_ready,
   output logic [DATA_W-1:0] snk_data,
   output logic              snk_sop,
   output logic              snk_eop,
   output logic [CH_W-1:0]   snk_chan,
   output logic [SNK_PW-1:0] snk_err
);
   generate
      if (SRC_W < 0 || SRC_W > MAX_ERR) begin : g_bad_src
         $error("SRC_W must lie in 0..MAX_ERR");
      end
      if (SNK_W < 0 || SNK_W > MAX_ERR) begin : g_bad_snk
         $error("SNK_W must lie in 0..MAX_ERR");
      end
      if (TAG_W < 1 || DATA_W < 1 || CH_W < 1) begin : g_bad_w
         $error("TAG_W, DATA_W and CH_W must be at least 1");
      end
   endgenerate

   st_passthru #(
      .DATA_W (DATA_W),
      .CH_W   (CH_W)
   ) u_pass (
      .in_valid  (src_valid),
      .in_data   (src_data),
      .in_sop    (src_sop),
      .in_eop    (src_eop),
      .in_chan   (src_chan),
      .out_ready (snk_ready),
      .out_valid (snk_valid),
      .out_data  (snk_data),
      .out_sop   (snk_sop),
      .out_eop   (snk_eop),
      .out_chan  (snk_chan),
      .in_ready  (src_ready)
   );

   err_router #(
      .MAX_ERR  (MAX_ERR),
      .TAG_W    (TAG_W),
      .SRC_W    (SRC_W),
      .SNK_W    (SNK_W),
      .SRC_TAGS (SRC_TAGS),
      .SNK_TAGS (SNK_TAGS)
   ) u_route (
      .src_err (src_err),
      .snk_err (snk_err)
   );
endmodule

// File: tb/sim_st_err_adapter.sv
module sim_st_err_adapter;
   typedef int tags_t [8];

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;

   logic        valid = 1'b0, sop = 1'b0, eop = 1'b0, ready = 1'b0;
   logic [15:0] data  = '0;
   logic [2:0]  chan  = '0;
   logic [7:0]  err   = '0;

   logic        o_valid, o_sop, o_eop, o_rdy;
   logic [15:0] o_data;
   logic [2:0]  o_chan;
   logic [2:0]  e0;
   logic [4:0]  e1;
   logic [1:0]  e2, e3;
   logic        e4;
   logic        r1v, r2v, r3v, r4v;

   localparam tags_t S0 = '{3,5,0,7,0,0,0,0};
   localparam tags_t K0 = '{5,0,3,0,0,0,0,0};
   localparam tags_t S1 = '{2,2,4,2,9,0,0,0};
   localparam tags_t K1 = '{2,2,0,0,6,0,0,0};
   localparam tags_t S2 = '{1,2,3,0,0,0,0,0};
   localparam tags_t K2 = '{3,8,0,0,0,0,0,0};
   localparam tags_t K3 = '{0,4,0,0,0,0,0,0};
   localparam tags_t S4 = '{1,0,1,0,0,0,0,0};
   localparam tags_t NONE = '{0,0,0,0,0,0,0,0};

   st_err_adapter #(.DATA_W(16), .CH_W(3), .SRC_W(4), .SNK_W(3),
      .SRC_TAGS(64'h0000_0000_0700_0503), .SNK_TAGS(64'h0000_0000_0003_0005)) u0 (
      .src_valid(valid), .src_ready(o_rdy), .src_data(data), .src_sop(sop),
      .src_eop(eop), .src_chan(chan), .src_err(err[3:0]), .snk_valid(o_valid),
      .snk_ready(ready), .snk_data(o_data), .snk_sop(o_sop), .snk_eop(o_eop),
      .snk_chan(o_chan), .snk_err(e0));

   st_err_adapter #(.DATA_W(16), .CH_W(3), .SRC_W(5), .SNK_W(5),
      .SRC_TAGS(64'h0000_0009_0204_0202), .SNK_TAGS(64'h0000_0006_0000_0202)) u1 (
      .src_valid(valid), .src_ready(r1v), .src_data(data), .src_sop(sop),
      .src_eop(eop), .src_chan(chan), .src_err(err[4:0]), .snk_valid(),
      .snk_ready(ready), .snk_data(), .snk_sop(), .snk_eop(), .snk_chan(),
      .snk_err(e1));

   st_err_adapter #(.DATA_W(16), .CH_W(3), .SRC_W(3), .SNK_W(2),
      .SRC_TAGS(64'h0000_0000_0003_0201), .SNK_TAGS(64'h0000_0000_0000_0803)) u2 (
      .src_valid(valid), .src_ready(r2v), .src_data(data), .src_sop(sop),
      .src_eop(eop), .src_chan(chan), .src_err(err[2:0]), .snk_valid(),
      .snk_ready(ready), .snk_data(), .snk_sop(), .snk_eop(), .snk_chan(),
      .snk_err(e2));

   st_err_adapter #(.DATA_W(16), .CH_W(3), .SRC_W(0), .SNK_W(2),
      .SRC_TAGS(64'h0), .SNK_TAGS(64'h0000_0000_0000_0400)) u3 (
      .src_valid(valid), .src_ready(r3v), .src_data(data), .src_sop(sop),
      .src_eop(eop), .src_chan(chan), .src_err(err[0]), .snk_valid(),
      .snk_ready(ready), .snk_data(), .snk_sop(), .snk_eop(), .snk_chan(),
      .snk_err(e3));

   st_err_adapter #(.DATA_W(16), .CH_W(3), .SRC_W(3), .SNK_W(0),
      .SRC_TAGS(64'h0000_0000_0001_0001), .SNK_TAGS(64'h0)) u4 (
      .src_valid(valid), .src_ready(r4v), .src_data(data), .src_sop(sop),
      .src_eop(eop), .src_chan(chan), .src_err(err[2:0]), .snk_valid(),
      .snk_ready(ready), .snk_data(), .snk_sop(), .snk_eop(), .snk_chan(),
      .snk_err(e4));

   // reference: tagged consumer bits first, then one catch-all over what is left
   function automatic logic [7:0] model(input int sw, input int kw,
                                        input tags_t st, input tags_t kt,
                                        input logic [7:0] s);
      logic [7:0] r;
      bit taken [8];
      bit found, caught;
      r = '0;
      caught = 0;
      for (int i = 0; i < 8; i++) taken[i] = 0;
      for (int k = 0; k < kw; k++) begin
         found = 0;
         if (kt[k] != 0) begin
            for (int i = 0; i < sw; i++) begin
               if (!found && !taken[i] && st[i] == kt[k]) begin
                  r[k] = s[i];
                  taken[i] = 1;
                  found = 1;
               end
            end
         end
      end
      for (int k = 0; k < kw; k++) begin
         if (kt[k] == 0 && !caught) begin
            caught = 1;
            for (int i = 0; i < sw; i++) if (!taken[i]) r[k] = r[k] | s[i];
         end
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R1 data",  {16'h0, o_data}, {16'h0, data});
      chk("R1 ctrl",  {26'h0, o_valid, o_sop, o_eop, o_chan}, {26'h0, valid, sop, eop, chan});
      chk("R2 ready", {28'h0, o_rdy, r1v, r2v, r3v}, {28'h0, {4{ready}}});
      chk("R2 ready u4", {31'h0, r4v}, {31'h0, ready});
      chk("R3 R5 u0", {29'h0, e0}, {24'h0, model(4, 3, S0, K0, err)});
      chk("R4 R6 R7 u1", {27'h0, e1}, {24'h0, model(5, 5, S1, K1, err)});
      chk("R7 R8 u2", {30'h0, e2}, {24'h0, model(3, 2, S2, K2, err)});
      chk("R9 u3", {30'h0, e3}, {24'h0, model(0, 2, NONE, K3, err)});
      chk("R9 u4", {31'h0, e4}, 32'h0);
   endtask

   task automatic apply(input logic [7:0] ev);
      @(negedge clk);
      err   = ev;
      data  = 16'($urandom);
      chan  = 3'($urandom);
      {valid, sop, eop, ready} = 4'($urandom);
      #5;
      compare_all();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      // quiet state: all inputs zero give all outputs zero (R1, R8)
      chk("R1 idle", {16'h0, o_data}, 32'h0);
      chk("R8 idle", {22'h0, e0, e1, e2}, 32'h0);
      rst = 1'b0;

      // direct tag matches and catch-all in u0 (R3, R5)
      apply(8'b0000_0010);
      chk("R3 src1->snk0", {29'h0, e0}, 32'h1);
      apply(8'b0000_0001);
      chk("R3 src0->snk2", {29'h0, e0}, 32'h4);
      apply(8'b0000_1000);
      chk("R5 tag7 leftover", {29'h0, e0}, 32'h2);
      apply(8'b0000_0100);
      chk("R5 catch leftover", {29'h0, e0}, 32'h2);

      // repeated tags in u1 (R4, R6)
      apply(8'b0000_0010);
      chk("R4 second tag2 bit", {27'h0, e1}, 32'h02);
      apply(8'b0000_1000);
      chk("R4 third tag2 to catch", {27'h0, e1}, 32'h04);
      apply(8'b0001_1101);
      chk("R6 extra catch-all low", {31'h0, e1[3]}, 32'h0);
      chk("R7 tag6 unmatched", {31'h0, e1[4]}, 32'h0);

      // discarded bits in u2 (R8)
      apply(8'b0000_0011);
      chk("R8 discarded bits", {30'h0, e2}, 32'h0);
      apply(8'b0000_0111);
      chk("R8 matched bit only", {30'h0, e2}, 32'h1);

      // missing sides (R9)
      apply(8'b1111_1111);
      chk("R9 no producer field", {30'h0, e3}, 32'h0);
      chk("R9 no consumer field", {31'h0, e4}, 32'h0);

      // one-hot sweep and random patterns
      for (int b = 0; b < 8; b++) apply(8'(1 << b));
      for (int n = 0; n < 300; n++) apply(8'($urandom));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule